// File: doc/BRIEF.md
# Dual-Channel IDE Bus-Master Register Window

This block is the register front end of a two-channel IDE bus-master controller. It decodes single-cycle accesses on a simple synchronous register bus into a 16-byte I/O window. The window is split into two 8-byte slices, one per channel. The slice for channel 0 sits at offsets 0 to 7 and the slice for channel 1 at offsets 8 to 15. The lower half of each slice is a group of four byte-wide registers. The upper half is a 32-bit port that holds the physical address of the descriptor table.

The two channels share one mode byte. That byte mirrors the interrupt request of each channel and holds a block bit for each channel. The block ORs the unblocked requests into a single level-sensitive interrupt line. The channel status byte mixes three kinds of bit: read-only bits, bits that are cleared by writing a one, and plain storage bits. The DMA engine outside this block drives the active, error and request inputs, and it reads the command and descriptor address back out.

Top module: `bm_window_top`

## Requirements
- R1: After reset, a byte read of every offset returns 0 (with the active inputs low), `irq_out` is low, and `rd_data` is 0.
- R2: Address bit 3 selects the channel and address bit 2 selects between the register group (0) and the descriptor port (1). Within the group, address bits 1:0 select: 0 the command register, 1 the shared mode register, 2 the channel status register, 3 the channel timing register. A write to one channel's slice leaves the other channel's registers unchanged.
- R3: `acc_size` encodes 0 = 1 byte, 1 = 2 bytes, 2 or 3 = 4 bytes. A register-group read that is wider than one byte returns 32'h0000FFFF for 2 bytes and 32'hFFFFFFFF for 4 bytes. A register-group write that is wider than one byte changes nothing.
- R4: Status byte layout: bit 0 is the channel's `chan_active` input and is read-only; bits 5 and 6 store the written value; bits 1 and 2 clear where a written bit is one and otherwise keep their value; bits 3, 4 and 7 read as zero.
- R5: Status bit 2 sets on a rising edge of the channel's `chan_irq_req`. Status bit 1 sets when `chan_err_pulse` is high. In a cycle that both sets a bit and writes a one to clear it, the set wins.
- R6: A byte write to the mode register through either slice changes only bits 4 (block channel 0) and 5 (block channel 1). Bits 7:6 and 1:0 stay zero.
- R7: Mode bit 2 follows `chan_irq_req[0]` and mode bit 3 follows `chan_irq_req[1]`, one clock later.
- R8: `irq_out` is high exactly when (mode bit 2 is set and bit 4 is clear) or (mode bit 3 is set and bit 5 is clear).
- R9: Each channel has its own 8-bit timing register with full read/write access.
- R10: The descriptor port holds 32 bits per channel. A 1-byte write updates the lane given by address bits 1:0 from `acc_wdata[7:0]`. A 2-byte write updates lanes 1:0 or 3:2 (chosen by address bit 1) from `acc_wdata[15:0]`. A 4-byte write updates all lanes. Bits 1:0 always read as zero. Reads return the addressed byte, half or word right-justified.
- R11: The command register stores only bit 0 (start) and bit 3 (direction). Its other bits read as zero.
- R12: `rd_data` is updated on the clock edge that accepts a read. It holds its value through idle cycles and write cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| acc_en | input | 1 | Access strobe, one access per cycle |
| acc_we | input | 1 | 1 = write, 0 = read |
| acc_addr | input | 4 | Byte offset in the window |
| acc_size | input | 2 | Access width code |
| acc_wdata | input | 32 | Write data, right-justified |
| rd_data | output | 32 | Registered read data |
| chan_irq_req | input | 2 | Per-channel interrupt request level |
| chan_err_pulse | input | 2 | Per-channel error set pulse |
| chan_active | input | 2 | Per-channel transfer-active flag |
| irq_out | output | 1 | Combined level interrupt |

## Verification
The hardest case to reach is a status write whose clearing one lands in the same clock as a hardware set of that bit. The bench gets there by raising `chan_err_pulse` in the exact cycle in which it drives the status write, and then confirms that bit 1 survived. The interrupt gating is driven through every mix of request and block bits. For this the block bits are written through the slice of the other channel, which shows that the mode byte is truly shared.

// File: rtl/bmw_pkg.sv
package bmw_pkg;
  localparam int CH_COUNT    = 2;
  localparam int SLICE_BYTES = 8;
  localparam int WIN_BYTES   = CH_COUNT * SLICE_BYTES;
  localparam int ADDR_W      = $clog2(WIN_BYTES);
  localparam int SLICE_AW    = $clog2(SLICE_BYTES);
  localparam int CH_IDX_W    = ADDR_W - SLICE_AW;
  localparam int DATA_W      = 32;
  localparam int BYTE_W      = 8;
  localparam int LANES       = DATA_W / BYTE_W;
  localparam int LANE_W      = $clog2(LANES);

  // command byte: start and direction bits are kept
  localparam logic [BYTE_W-1:0] CMD_KEEP = 8'h09;

  // status bit positions
  localparam int ST_ACT  = 0;
  localparam int ST_ERR  = 1;
  localparam int ST_INT  = 2;
  localparam int ST_CAP  = 5;

  // mode byte positions
  localparam int MD_REQ_BASE = 2;
  localparam int MD_BLK_BASE = 4;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_WIDE = 2'd3
  } acc_size_e;

  typedef enum logic [1:0] {
    RS_CMD  = 2'd0,
    RS_MODE = 2'd1,
    RS_STAT = 2'd2,
    RS_TIME = 2'd3
  } reg_sel_e;

  typedef struct packed {
    logic                grp_wr;
    logic                grp_rd;
    logic                grp_wide;
    logic                desc_wr;
    logic                desc_rd;
    logic [CH_IDX_W-1:0] ch;
    reg_sel_e            sel;
    logic [LANE_W-1:0]   lane;
    acc_size_e           size;
  } dec_t;
endpackage

// File: rtl/bmw_decode.sv
module bmw_decode
  import bmw_pkg::*;
(
  input  logic              acc_en,
  input  logic              acc_we,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [1:0]        acc_size,
  output dec_t              dec
);
  logic in_desc;
  logic is_byte;

  always_comb begin
    in_desc      = acc_addr[SLICE_AW-1];
    is_byte      = (acc_size == SZ_BYTE);
    dec.ch       = acc_addr[ADDR_W-1:SLICE_AW];
    dec.sel      = reg_sel_e'(acc_addr[1:0]);
    dec.lane     = acc_addr[LANE_W-1:0];
    dec.size     = acc_size_e'(acc_size);
    dec.grp_wide = !is_byte;
    dec.grp_wr   = acc_en && acc_we && !in_desc && is_byte;
    dec.grp_rd   = acc_en && !acc_we && !in_desc;
    dec.desc_wr  = acc_en && acc_we && in_desc;
    dec.desc_rd  = acc_en && !acc_we && in_desc;
  end
endmodule

// File: rtl/bmw_chan.sv
module bmw_chan
  import bmw_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_we,
  input  logic              stat_we,
  input  logic              time_we,
  input  logic              desc_we,
  input  acc_size_e         size,
  input  logic [LANE_W-1:0] lane,
  input  logic [DATA_W-1:0] wdata,
  input  logic              irq_req,
  input  logic              err_pulse,
  input  logic              active,
  output logic [BYTE_W-1:0] cmd_q,
  output logic [BYTE_W-1:0] stat_rd,
  output logic [BYTE_W-1:0] time_q,
  output logic [DATA_W-1:0] desc_q
);
  logic [BYTE_W-1:0] cmd_d;
  logic [BYTE_W-1:0] time_d;
  logic              err_q, err_d;
  logic              int_q, int_d;
  logic [1:0]        cap_q, cap_d;
  logic              req_prev_q;
  logic              stat_en;

  // command and timing next state
  always_comb begin
    cmd_d  = wdata[BYTE_W-1:0] & CMD_KEEP;
    time_d = wdata[BYTE_W-1:0];
  end

  // status next state: set beats clear
  always_comb begin
    err_d = err_q;
    int_d = int_q;
    cap_d = cap_q;
    if (stat_we) begin
      cap_d = wdata[ST_CAP +: 2];
      if (wdata[ST_ERR]) err_d = 1'b0;
      if (wdata[ST_INT]) int_d = 1'b0;
    end
    if (err_pulse) err_d = 1'b1;
    if (irq_req && !req_prev_q) int_d = 1'b1;
    stat_en = stat_we || err_pulse || (irq_req && !req_prev_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q <= '0;
    end else if (cmd_we) begin
      cmd_q <= cmd_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      time_q <= '0;
    end else if (time_we) begin
      time_q <= time_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_q <= 1'b0;
      int_q <= 1'b0;
      cap_q <= '0;
    end else if (stat_en) begin
      err_q <= err_d;
      int_q <= int_d;
      cap_q <= cap_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_prev_q <= 1'b0;
    end else begin
      req_prev_q <= irq_req;
    end
  end

  always_comb begin
    stat_rd          = '0;
    stat_rd[ST_ACT]  = active;
    stat_rd[ST_ERR]  = err_q;
    stat_rd[ST_INT]  = int_q;
    stat_rd[ST_CAP +: 2] = cap_q;
  end

  // descriptor port: one register per byte lane
  logic [LANES-1:0] lane_we;

  always_comb begin
    lane_we = '0;
    if (desc_we) begin
      case (size)
        SZ_BYTE: lane_we[lane] = 1'b1;
        SZ_HALF: lane_we = lane[1] ? 4'b1100 : 4'b0011;
        default: lane_we = '1;
      endcase
    end
  end

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [BYTE_W-1:0] lane_d;
    logic [BYTE_W-1:0] lane_q;

    always_comb begin
      case (size)
        SZ_BYTE: lane_d = wdata[BYTE_W-1:0];
        SZ_HALF: lane_d = wdata[(l % 2)*BYTE_W +: BYTE_W];
        default: lane_d = wdata[l*BYTE_W +: BYTE_W];
      endcase
      if (l == 0) lane_d[1:0] = 2'b00;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        lane_q <= '0;
      end else if (lane_we[l]) begin
        lane_q <= lane_d;
      end
    end

    assign desc_q[l*BYTE_W +: BYTE_W] = lane_q;
  end
endmodule

// File: rtl/bmw_mode.sv
module bmw_mode
  import bmw_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                mode_we,
  input  logic [CH_COUNT-1:0] blk_wdata,
  input  logic [CH_COUNT-1:0] irq_req,
  output logic [BYTE_W-1:0]   mode_q,
  output logic                irq_out
);
  logic [CH_COUNT-1:0] req_q;
  logic [CH_COUNT-1:0] blk_q;
  logic [CH_COUNT-1:0] pend;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q <= '0;
    end else begin
      req_q <= irq_req;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      blk_q <= '0;
    end else if (mode_we) begin
      blk_q <= blk_wdata;
    end
  end

  for (genvar c = 0; c < CH_COUNT; c++) begin : g_pend
    assign pend[c] = req_q[c] && !blk_q[c];
  end

  always_comb begin
    mode_q = '0;
    mode_q[MD_REQ_BASE +: CH_COUNT] = req_q;
    mode_q[MD_BLK_BASE +: CH_COUNT] = blk_q;
    irq_out = |pend;
  end
endmodule

// File: rtl/bm_window_top.sv
module bm_window_top
  import bmw_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                acc_en,
  input  logic                acc_we,
  input  logic [ADDR_W-1:0]   acc_addr,
  input  logic [1:0]          acc_size,
  input  logic [DATA_W-1:0]   acc_wdata,
  output logic [DATA_W-1:0]   rd_data,
  input  logic [CH_COUNT-1:0] chan_irq_req,
  input  logic [CH_COUNT-1:0] chan_err_pulse,
  input  logic [CH_COUNT-1:0] chan_active,
  output logic                irq_out
);
  localparam logic [DATA_W-1:0] HALF_ONES = {{(DATA_W-16){1'b0}}, 16'hFFFF};

  dec_t dec;

  bmw_decode u_dec (
    .acc_en   (acc_en),
    .acc_we   (acc_we),
    .acc_addr (acc_addr),
    .acc_size (acc_size),
    .dec      (dec)
  );

  logic [BYTE_W-1:0] cmd_arr  [CH_COUNT];
  logic [BYTE_W-1:0] stat_arr [CH_COUNT];
  logic [BYTE_W-1:0] time_arr [CH_COUNT];
  logic [DATA_W-1:0] desc_arr [CH_COUNT];
  logic [BYTE_W-1:0] mode_bits;
  logic              mode_we;

  assign mode_we = dec.grp_wr && (dec.sel == RS_MODE);

  for (genvar c = 0; c < CH_COUNT; c++) begin : g_ch
    logic hit;
    assign hit = (dec.ch == CH_IDX_W'(c));

    bmw_chan u_chan (
      .clk       (clk),
      .rst_n     (rst_n),
      .cmd_we    (dec.grp_wr && hit && (dec.sel == RS_CMD)),
      .stat_we   (dec.grp_wr && hit && (dec.sel == RS_STAT)),
      .time_we   (dec.grp_wr && hit && (dec.sel == RS_TIME)),
      .desc_we   (dec.desc_wr && hit),
      .size      (dec.size),
      .lane      (dec.lane),
      .wdata     (acc_wdata),
      .irq_req   (chan_irq_req[c]),
      .err_pulse (chan_err_pulse[c]),
      .active    (chan_active[c]),
      .cmd_q     (cmd_arr[c]),
      .stat_rd   (stat_arr[c]),
      .time_q    (time_arr[c]),
      .desc_q    (desc_arr[c])
    );
  end

  bmw_mode u_mode (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode_we   (mode_we),
    .blk_wdata (acc_wdata[MD_BLK_BASE +: CH_COUNT]),
    .irq_req   (chan_irq_req),
    .mode_q    (mode_bits),
    .irq_out   (irq_out)
  );

  // read path
  logic [DATA_W-1:0] rd_q, rd_d;
  logic              rd_en;
  logic [DATA_W-1:0] desc_sel;
  logic [BYTE_W-1:0] grp_byte;

  always_comb begin
    desc_sel = desc_arr[dec.ch];
    case (dec.sel)
      RS_CMD:  grp_byte = cmd_arr[dec.ch];
      RS_MODE: grp_byte = mode_bits;
      RS_STAT: grp_byte = stat_arr[dec.ch];
      default: grp_byte = time_arr[dec.ch];
    endcase
  end

  always_comb begin
    rd_en = dec.grp_rd || dec.desc_rd;
    rd_d  = '0;
    if (dec.grp_rd) begin
      if (dec.grp_wide) begin
        rd_d = (dec.size == SZ_HALF) ? HALF_ONES : '1;
      end else begin
        rd_d = DATA_W'(grp_byte);
      end
    end else begin
      case (dec.size)
        SZ_BYTE: rd_d = DATA_W'(desc_sel[{dec.lane, 3'b000} +: BYTE_W]);
        SZ_HALF: rd_d = DATA_W'(desc_sel[{dec.lane[1], 4'b0000} +: 16]);
        default: rd_d = desc_sel;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q <= '0;
    end else if (rd_en) begin
      rd_q <= rd_d;
    end
  end

  assign rd_data = rd_q;
endmodule

// File: rtl/bm_window_chk.sv
module bm_window_chk
  import bmw_pkg::*;
(
  input logic                clk,
  input logic                rst_n,
  input logic                acc_en,
  input logic                acc_we,
  input logic [2:0]          acc_off,
  input logic [1:0]          acc_size,
  input logic [1:0]          blk_wdata,
  input logic [DATA_W-1:0]   rd_data,
  input logic [CH_COUNT-1:0] chan_irq_req,
  input logic [BYTE_W-1:0]   mode_bits,
  input logic                irq_out
);
  AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && ($past(chan_irq_req) == '0)) |-> !irq_out); // R8

  AST_MODE_MIRROR: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (mode_bits[MD_REQ_BASE +: CH_COUNT] == $past(chan_irq_req))); // R7

  AST_MODE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_en && acc_we && acc_size == 2'd0 && acc_off == 3'd1)
      |=> (mode_bits[MD_BLK_BASE +: CH_COUNT] == $past(blk_wdata))
          && (mode_bits[7:6] == 2'b00) && (mode_bits[1:0] == 2'b00)); // R6

  AST_WIDE_HALF_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_en && !acc_we && !acc_off[2] && acc_size == 2'd1)
      |=> (rd_data == 32'h0000_FFFF)); // R3

  AST_WIDE_WORD_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_en && !acc_we && !acc_off[2] && acc_size[1])
      |=> (rd_data == 32'hFFFF_FFFF)); // R3

  AST_STAT_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_en && !acc_we && acc_size == 2'd0 && acc_off == 3'd2)
      |=> (rd_data[31:7] == '0) && (rd_data[4:3] == 2'b00)); // R4

  AST_DESC_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_en && !acc_we && acc_off == 3'd4 && acc_size != 2'd1)
      |=> (rd_data[1:0] == 2'b00)); // R10

  AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!acc_en || acc_we) |=> $stable(rd_data)); // R12
endmodule

bind bm_window_top bm_window_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .acc_en       (acc_en),
  .acc_we       (acc_we),
  .acc_off      (acc_addr[2:0]),
  .acc_size     (acc_size),
  .blk_wdata    (acc_wdata[5:4]),
  .rd_data      (rd_data),
  .chan_irq_req (chan_irq_req),
  .mode_bits    (mode_bits),
  .irq_out      (irq_out)
);

// File: tb/bm_window_top_tb.sv
module bm_window_top_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic        clk;
  logic        rst_n;
  logic        acc_en;
  logic        acc_we;
  logic [3:0]  acc_addr;
  logic [1:0]  acc_size;
  logic [31:0] acc_wdata;
  logic [31:0] rd_data;
  logic [1:0]  chan_irq_req;
  logic [1:0]  chan_err_pulse;
  logic [1:0]  chan_active;
  logic        irq_out;

  int checks;
  int errors;
  logic [31:0] exp_q [$];
  string       tag_q [$];
  logic        rd_pend;
  logic [31:0] last_exp;

  bm_window_top u_dut (
    .clk            (clk),
    .rst_n          (rst_n),
    .acc_en         (acc_en),
    .acc_we         (acc_we),
    .acc_addr       (acc_addr),
    .acc_size       (acc_size),
    .acc_wdata      (acc_wdata),
    .rd_data        (rd_data),
    .chan_irq_req   (chan_irq_req),
    .chan_err_pulse (chan_err_pulse),
    .chan_active    (chan_active),
    .irq_out        (irq_out)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [1:0] sz, input logic [31:0] d);
    @(negedge clk);
    acc_en = 1'b1; acc_we = 1'b1; acc_addr = a; acc_size = sz; acc_wdata = d;
    @(negedge clk);
    acc_en = 1'b0; acc_we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, input logic [1:0] sz, input logic [31:0] exp,
                    input string req);
    @(negedge clk);
    acc_en = 1'b1; acc_we = 1'b0; acc_addr = a; acc_size = sz;
    exp_q.push_back(exp);
    tag_q.push_back(req);
    last_exp = exp;
    @(negedge clk);
    acc_en = 1'b0;
  endtask

  task automatic chk_irq(input logic exp, input string req);
    @(negedge clk);
    @(negedge clk);
    check(req, {31'd0, irq_out}, {31'd0, exp});
  endtask

  // monitor: a read accepted at a rising edge is compared at the next falling edge
  always @(posedge clk) rd_pend <= rst_n && acc_en && !acc_we;

  always @(negedge clk) begin
    if (rd_pend) begin
      if (exp_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL R12: actual read with empty scoreboard expected none");
      end else begin
        check(tag_q.pop_front(), rd_data, exp_q.pop_front());
      end
    end
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    checks = 0; errors = 0; rd_pend = 1'b0; last_exp = '0;
    rst_n = 1'b0; acc_en = 1'b0; acc_we = 1'b0; acc_addr = '0; acc_size = '0;
    acc_wdata = '0; chan_irq_req = '0; chan_err_pulse = '0; chan_active = '0;
    repeat (3) @(negedge clk);
    check("R1 rd_data", rd_data, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 irq_out", {31'd0, irq_out}, 32'h0);

    // R1: every offset reads zero
    for (int i = 0; i < 16; i++) rd(4'(i), 2'd0, 32'h0, "R1 offset");

    // R11 / R2: command register masking and channel separation
    wr(4'd0, 2'd0, 32'hFF);
    wr(4'd8, 2'd0, 32'h01);
    rd(4'd0, 2'd0, 32'h09, "R11 cmd ch0");
    rd(4'd8, 2'd0, 32'h01, "R2 cmd ch1");

    // R9: per-channel timing
    wr(4'd3, 2'd0, 32'hA5);
    wr(4'd11, 2'd0, 32'h5A);
    rd(4'd3, 2'd0, 32'hA5, "R9 timing ch0");
    rd(4'd11, 2'd0, 32'h5A, "R9 timing ch1");

    // R3: wide accesses to the register group
    wr(4'd3, 2'd1, 32'h1234);
    wr(4'd8, 2'd2, 32'hFFFF_FFFF);
    rd(4'd3, 2'd0, 32'hA5, "R3 wide write ignored");
    rd(4'd8, 2'd0, 32'h01, "R3 wide cmd write ignored");
    rd(4'd2, 2'd1, 32'h0000_FFFF, "R3 half read");
    rd(4'd0, 2'd2, 32'hFFFF_FFFF, "R3 word read");
    rd(4'd9, 2'd3, 32'hFFFF_FFFF, "R3 size3 read");

    // R7 / R8 / R6: interrupt mirror and gating
    @(negedge clk); chan_irq_req = 2'b01;
    chk_irq(1'b1, "R8 ch0 unblocked");
    rd(4'd1, 2'd0, 32'h04, "R7 mode mirror ch0");
    rd(4'd2, 2'd0, 32'h04, "R5 int set on rise");
    wr(4'd9, 2'd0, 32'hFF);
    rd(4'd1, 2'd0, 32'h34, "R6 mode via ch1 slice");
    chk_irq(1'b0, "R8 both blocked");
    wr(4'd1, 2'd0, 32'h00);
    rd(4'd9, 2'd0, 32'h04, "R6 mode cleared");
    chk_irq(1'b1, "R8 unblocked again");
    @(negedge clk); chan_irq_req = 2'b11;
    wr(4'd1, 2'd0, 32'h10);
    rd(4'd1, 2'd0, 32'h1C, "R7 mode mirror both");
    chk_irq(1'b1, "R8 ch1 drives");
    wr(4'd1, 2'd0, 32'h20);
    chk_irq(1'b1, "R8 ch0 drives");
    wr(4'd1, 2'd0, 32'h30);
    chk_irq(1'b0, "R8 both masked");
    @(negedge clk); chan_irq_req = 2'b00;
    rd(4'd1, 2'd0, 32'h30, "R7 mirror follows low");
    wr(4'd1, 2'd0, 32'h00);
    chk_irq(1'b0, "R8 idle");

    // R4 / R5: status semantics
    @(negedge clk); chan_active = 2'b01;
    rd(4'd2, 2'd0, 32'h05, "R4 active bit");
    wr(4'd2, 2'd0, 32'hFF);
    rd(4'd2, 2'd0, 32'h61, "R4 w1c and store");
    wr(4'd2, 2'd0, 32'h00);
    rd(4'd2, 2'd0, 32'h01, "R4 store bits cleared");
    @(negedge clk); chan_err_pulse = 2'b10;
    @(negedge clk); chan_err_pulse = 2'b00;
    rd(4'd10, 2'd0, 32'h06, "R5 err set ch1");
    wr(4'd10, 2'd0, 32'h02);
    rd(4'd10, 2'd0, 32'h04, "R4 clear err only");
    wr(4'd10, 2'd0, 32'h04);
    rd(4'd10, 2'd0, 32'h00, "R4 clear int");
    @(negedge clk);
    acc_en = 1'b1; acc_we = 1'b1; acc_addr = 4'd10; acc_size = 2'd0;
    acc_wdata = 32'h02; chan_err_pulse = 2'b10;
    @(negedge clk);
    acc_en = 1'b0; acc_we = 1'b0; chan_err_pulse = 2'b00;
    rd(4'd10, 2'd0, 32'h02, "R5 set wins over clear");

    // R10: descriptor port
    wr(4'd4, 2'd2, 32'hDEAD_BEEF);
    rd(4'd4, 2'd2, 32'hDEAD_BEEC, "R10 word write aligned");
    wr(4'd6, 2'd0, 32'h77);
    rd(4'd4, 2'd2, 32'hDE77_BEEC, "R10 byte lane 2");
    wr(4'd4, 2'd0, 32'hFF);
    rd(4'd4, 2'd2, 32'hDE77_BEFC, "R10 byte lane 0 aligned");
    rd(4'd7, 2'd0, 32'h0000_00DE, "R10 byte read lane 3");
    wr(4'd12, 2'd1, 32'h1234);
    rd(4'd12, 2'd2, 32'h0000_1234, "R10 half write ch1");
    rd(4'd14, 2'd1, 32'h0000_0000, "R10 half read upper");
    rd(4'd4, 2'd1, 32'h0000_BEFC, "R10 ch0 unaffected");

    // R12: read data holds through idle and write cycles
    repeat (3) @(negedge clk);
    check("R12 hold idle", rd_data, last_exp);
    wr(4'd3, 2'd0, 32'h11);
    check("R12 hold write", rd_data, last_exp);

    repeat (2) @(negedge clk);
    if (exp_q.size() != 0) begin
      checks++; errors++;
      $display("FAIL R12: actual %0d reads outstanding expected 0", exp_q.size());
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule